// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block turns single read or write requests into timed accesses on an asynchronous static memory bus of the NOR-flash or SRAM kind. A requester offers one access at a time on a valid/ready request port. The sequencer then runs the access through four phases: address setup, address hold, data and bus turnaround. Each phase has its own programmable length. The external side has an address, a chip select, an output enable, a write enable and a wait input. The data bus is split into an outgoing word, an incoming word and a drive enable.

Request back-pressure works like this. `req_ready` is high only while the sequencer is idle and the bank is enabled. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the requester must take when it appears. The timing fields and the control word are static configuration and must not change while an access is in flight.

The memory may stretch an access with its wait pin. The pin passes through a two-stage synchronizer. It then freezes only the data phase, and only when waiting is enabled in the control word.

Top module: `sram_access_seq`

## Requirements
- R1: A request is taken only when the sequencer is idle and the bank-enable bit (control word bit 0) is 1. `req_ready` shows exactly that condition. While the bank is disabled, no access starts and `mem_cs_n` stays high.
- R2: The address-setup phase lasts `cfg_addr_setup + 1` cycles. During it `mem_cs_n` is low and both `mem_oe_n` and `mem_we_n` are high.
- R3: The address-hold phase follows and lasts `cfg_addr_hold + 1` cycles, with the same pin levels as in R2. A hold value of 0 counts as 1.
- R4: The data phase lasts `cfg_data_setup + 3` cycles for a read and `cfg_data_setup + 1` cycles for a write. A value of 0 counts as 1. `mem_oe_n` is low during a read data phase and `mem_we_n` is low during a write data phase. Neither is low at any other time, and the two are never low together.
- R5: The turnaround phase lasts `cfg_turnaround + 1` cycles. During it all strobes and the chip select are high. `req_ready` rises in the cycle after it ends.
- R6: `mem_cs_n` is low without a break from the first address-setup cycle through the last data-phase cycle. It rises directly after the data phase.
- R7: For a write, `mem_dout_en` is high and `mem_dout` equals the request's write data in every data-phase cycle. `mem_dout_en` is never high during a read access or while idle.
- R8: For a read, `mem_din` is captured on the last data-phase cycle. `rsp_valid` pulses for exactly one cycle, in the first turnaround cycle, and for a read `rsp_rdata` carries the captured word in that cycle. A write also produces the pulse.
- R9: Waiting is enabled by control-word bit 15. Its polarity comes from control-word bit 9: 1 means `mem_wait` is active-high and 0 means active-low. While bit 15 is 0, `mem_wait` has no effect on any phase length.
- R10: While waiting is enabled and the synchronized wait is active, the data phase does not end. After `mem_wait` goes inactive, the data phase ends exactly 5 cycles later: 2 cycles of synchronizer and then 3 more data cycles.
- R11: The address-setup and address-hold lengths are the same whether or not wait is active.
- R12: `mem_addr` equals the request address and stays stable from the first address-setup cycle through the end of the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ctrl | input | 16 | Control word: bit 0 bank enable, bit 9 wait polarity, bit 15 wait enable; bits 1, 3:2, 5:4 and 14 carry mode fields that do not change the timing |
| cfg_addr_setup | input | 4 | Address-setup length minus one |
| cfg_addr_hold | input | 4 | Address-hold length minus one (0 counts as 1) |
| cfg_data_setup | input | 8 | Data-phase length base (0 counts as 1) |
| cfg_turnaround | input | 4 | Turnaround length minus one |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and bank enabled |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 20 | Access address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_valid` on reads |
| mem_addr | output | 20 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dout | output | 16 | Data driven toward the memory |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 16 | Data returned by the memory |
| mem_wait | input | 1 | Memory wait request, polarity per control word |

## Verification
The bench measures the length of each phase at the pins for a table of timing settings. The table includes the all-zero case, where the hold and data clamps apply, and the all-maximum case. A design that forgot a clamp or swapped the read and write data offsets would show a phase one or two cycles off. The read model returns data only while the output enable is low, so capturing one cycle late or early shows up as a wrong `rsp_rdata`. The wait tests use both polarities. They hold wait for several cycles and count the exact cycles from release to the end of the data phase, so a design that froze address phases, ignored polarity, dropped a synchronizer stage or honoured wait while disabled would give the wrong count.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ASET = 3'd1,
    PH_AHLD = 3'd2,
    PH_DATA = 3'd3,
    PH_TURN = 3'd4
  } phase_e;

  // control word bit positions that decide behaviour
  localparam int unsigned CTRL_W        = 16;
  localparam int unsigned BIT_BANK_EN   = 0;
  localparam int unsigned BIT_MUX_MODE  = 1;
  localparam int unsigned LSB_MEM_KIND  = 2;
  localparam int unsigned LSB_BUS_WIDTH = 4;
  localparam int unsigned BIT_WAIT_POL  = 9;
  localparam int unsigned BIT_EXT_MODE  = 14;
  localparam int unsigned BIT_WAIT_EN   = 15;

  typedef struct packed {
    logic bank_en;
    logic wait_en;
    logic wait_pol;
  } seq_flags_t;

endpackage

// File: rtl/sram_cfg_decode.sv
module sram_cfg_decode
  import sram_seq_pkg::*;
#(
  parameter int unsigned AS_W  = 4,
  parameter int unsigned AH_W  = 4,
  parameter int unsigned DS_W  = 8,
  parameter int unsigned TA_W  = 4,
  parameter int unsigned CNT_W = 9
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [AS_W-1:0]   addr_setup,
  input  logic [AH_W-1:0]   addr_hold,
  input  logic [DS_W-1:0]   data_setup,
  input  logic [TA_W-1:0]   turnaround,
  output seq_flags_t        flags,
  output logic [CNT_W-1:0]  aset_cnt,
  output logic [CNT_W-1:0]  ahld_cnt,
  output logic [CNT_W-1:0]  data_rd_cnt,
  output logic [CNT_W-1:0]  data_wr_cnt,
  output logic [CNT_W-1:0]  turn_cnt
);

  logic [AH_W-1:0] hold_eff;
  logic [DS_W-1:0] data_eff;
  logic            unused_mode_bits;

  always_comb begin
    flags.bank_en  = ctrl[BIT_BANK_EN];
    flags.wait_en  = ctrl[BIT_WAIT_EN];
    flags.wait_pol = ctrl[BIT_WAIT_POL];
  end

  // mode fields are carried in the word but do not shape timing
  assign unused_mode_bits = ^{ctrl[BIT_MUX_MODE], ctrl[LSB_MEM_KIND +: 2],
                              ctrl[LSB_BUS_WIDTH +: 2], ctrl[BIT_EXT_MODE],
                              ctrl[13:10], ctrl[8:6]};

  // zero is illegal for hold and data lengths: clamp to one
  assign hold_eff = (addr_hold == '0)  ? AH_W'(1) : addr_hold;
  assign data_eff = (data_setup == '0) ? DS_W'(1) : data_setup;

  // counters run down to zero, so a count of N gives N+1 cycles
  assign aset_cnt    = CNT_W'(addr_setup);
  assign ahld_cnt    = CNT_W'(hold_eff);
  assign data_rd_cnt = CNT_W'(data_eff) + CNT_W'(2);
  assign data_wr_cnt = CNT_W'(data_eff);
  assign turn_cnt    = CNT_W'(turnaround);

endmodule

// File: rtl/sram_wait_sync.sv
module sram_wait_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_raw,
  input  logic wait_en,
  input  logic wait_pol,
  output logic wait_act
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= wait_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], wait_raw};
      end
    end
  endgenerate

  // polarity 1: high means wait; polarity 0: low means wait
  assign wait_act = wait_en & (sync_q[STAGES-1] == wait_pol);

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned CNT_W     = 9,
  parameter int unsigned WAIT_TAIL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic [CNT_W-1:0] aset_cnt,
  input  logic [CNT_W-1:0] ahld_cnt,
  input  logic [CNT_W-1:0] data_rd_cnt,
  input  logic [CNT_W-1:0] data_wr_cnt,
  input  logic [CNT_W-1:0] turn_cnt,
  input  logic             wait_act,
  output phase_e           phase,
  output logic             data_done
);

  localparam logic [CNT_W-1:0] TAIL_CNT = CNT_W'(WAIT_TAIL - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign data_done = (phase_q == PH_DATA) && !wait_act && cnt_zero;
  assign phase     = phase_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_ASET;
          cnt_d   = aset_cnt;
        end
      end
      PH_ASET: begin
        if (cnt_zero) begin
          phase_d = PH_AHLD;
          cnt_d   = ahld_cnt;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_AHLD: begin
        if (cnt_zero) begin
          phase_d = PH_DATA;
          cnt_d   = is_write ? data_wr_cnt : data_rd_cnt;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_DATA: begin
        if (wait_act) begin
          // frozen: a fixed tail remains once wait clears
          cnt_d = TAIL_CNT;
        end else if (cnt_zero) begin
          phase_d = PH_TURN;
          cnt_d   = turn_cnt;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_TURN: begin
        if (cnt_zero) phase_d = PH_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned AS_W        = 4,
  parameter int unsigned AH_W        = 4,
  parameter int unsigned DS_W        = 8,
  parameter int unsigned TA_W        = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WAIT_TAIL   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cfg_ctrl,
  input  logic [AS_W-1:0]   cfg_addr_setup,
  input  logic [AH_W-1:0]   cfg_addr_hold,
  input  logic [DS_W-1:0]   cfg_data_setup,
  input  logic [TA_W-1:0]   cfg_turnaround,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  input  logic              mem_wait
);

  // counter must hold the largest read data count (data field + 2)
  localparam int unsigned CNT_W = DS_W + 1;

  seq_flags_t        flags;
  logic [CNT_W-1:0]  aset_cnt, ahld_cnt, data_rd_cnt, data_wr_cnt, turn_cnt;
  logic              wait_act;
  logic              accept;
  logic              data_done;
  phase_e            phase;

  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;

  sram_cfg_decode #(
    .AS_W (AS_W),
    .AH_W (AH_W),
    .DS_W (DS_W),
    .TA_W (TA_W),
    .CNT_W(CNT_W)
  ) cfg_i (
    .ctrl       (cfg_ctrl),
    .addr_setup (cfg_addr_setup),
    .addr_hold  (cfg_addr_hold),
    .data_setup (cfg_data_setup),
    .turnaround (cfg_turnaround),
    .flags      (flags),
    .aset_cnt   (aset_cnt),
    .ahld_cnt   (ahld_cnt),
    .data_rd_cnt(data_rd_cnt),
    .data_wr_cnt(data_wr_cnt),
    .turn_cnt   (turn_cnt)
  );

  sram_wait_sync #(
    .STAGES(SYNC_STAGES)
  ) wsync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wait_raw(mem_wait),
    .wait_en (flags.wait_en),
    .wait_pol(flags.wait_pol),
    .wait_act(wait_act)
  );

  assign req_ready = (phase == PH_IDLE) && flags.bank_en;
  assign accept    = req_valid && req_ready;

  sram_phase_fsm #(
    .CNT_W    (CNT_W),
    .WAIT_TAIL(WAIT_TAIL)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .is_write   (wr_q),
    .aset_cnt   (aset_cnt),
    .ahld_cnt   (ahld_cnt),
    .data_rd_cnt(data_rd_cnt),
    .data_wr_cnt(data_wr_cnt),
    .turn_cnt   (turn_cnt),
    .wait_act   (wait_act),
    .phase      (phase),
    .data_done  (data_done)
  );

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // read capture and completion pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= data_done;
      if (data_done && !wr_q) rdata_q <= mem_din;
    end
  end

  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rdata_q;
  assign mem_addr    = addr_q;
  assign mem_cs_n    = !((phase == PH_ASET) || (phase == PH_AHLD) || (phase == PH_DATA));
  assign mem_oe_n    = !((phase == PH_DATA) && !wr_q);
  assign mem_we_n    = !((phase == PH_DATA) && wr_q);
  assign mem_dout_en = (phase == PH_DATA) && wr_q;
  assign mem_dout    = wdata_q;

endmodule

// File: rtl/sram_access_seq_chk.sv
module sram_access_seq_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dout_en,
  input logic              wait_act
);

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n); // R1

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n); // R4

  AST_STROBE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n); // R6

  AST_CS_RELEASE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> $past(!mem_oe_n || !mem_we_n)); // R6

  AST_DRIVE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> !mem_we_n); // R7

  AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8

  AST_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_cs_n && $past(!mem_oe_n || !mem_we_n))); // R8

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R12

  AST_WAIT_HOLDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && wait_act) |=> !mem_oe_n); // R10

  AST_WAIT_HOLDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && wait_act) |=> !mem_we_n); // R10

endmodule

bind sram_access_seq sram_access_seq_chk #(
  .ADDR_W(ADDR_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dout_en(mem_dout_en),
  .wait_act   (wait_act)
);

// File: tb/sram_access_seq_tb_top.sv
`timescale 1ns/1ps
module sram_access_seq_tb_top;

  localparam int unsigned ADDR_W = 20;
  localparam int unsigned DATA_W = 16;

  typedef struct packed {
    logic [3:0]  aset;
    logic [3:0]  ahld;
    logic [7:0]  dset;
    logic [3:0]  turn;
    logic        wr;
    logic [19:0] addr;
    logic [15:0] wdata;
    logic [9:0]  exp_addr_cyc;  // setup + hold cycles
    logic [9:0]  exp_data_cyc;
    logic [9:0]  exp_turn_cyc;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [0:NVEC-1] = '{
    '{4'd0,  4'd1,  8'd1,   4'd0,  1'b0, 20'h01234, 16'h0000, 10'd3,  10'd4,   10'd1},
    '{4'd2,  4'd3,  8'd5,   4'd1,  1'b1, 20'h0ABCD, 16'hC3A5, 10'd7,  10'd6,   10'd2},
    '{4'd15, 4'd15, 8'd255, 4'd15, 1'b0, 20'hFFFFF, 16'h0000, 10'd32, 10'd258, 10'd16},
    '{4'd1,  4'd0,  8'd0,   4'd2,  1'b1, 20'h00010, 16'h1F2E, 10'd4,  10'd2,   10'd3},
    '{4'd0,  4'd0,  8'd0,   4'd0,  1'b0, 20'h55555, 16'h0000, 10'd3,  10'd4,   10'd1},
    '{4'd4,  4'd2,  8'd10,  4'd3,  1'b1, 20'h80001, 16'hFFFF, 10'd8,  10'd11,  10'd4},
    '{4'd3,  4'd1,  8'd7,   4'd0,  1'b0, 20'h3C3C3, 16'h0000, 10'd6,  10'd10,  10'd1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       cfg_ctrl = 16'h0001;
  logic [3:0]        cfg_addr_setup = '0;
  logic [3:0]        cfg_addr_hold = '0;
  logic [7:0]        cfg_data_setup = '0;
  logic [3:0]        cfg_turnaround = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;
  logic [DATA_W-1:0] mem_dout;
  logic [DATA_W-1:0] mem_din;
  logic              mem_wait = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  // memory model: data is present only while output enable is low
  assign mem_din = (!mem_oe_n) ? (mem_addr[15:0] ^ 16'h5A5A) : 16'h0000;

  sram_access_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl),
    .cfg_addr_setup(cfg_addr_setup), .cfg_addr_hold(cfg_addr_hold),
    .cfg_data_setup(cfg_data_setup), .cfg_turnaround(cfg_turnaround),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din), .mem_wait(mem_wait)
  );

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    cfg_addr_setup = v.aset;
    cfg_addr_hold  = v.ahld;
    cfg_data_setup = v.dset;
    cfg_turnaround = v.turn;
    req_valid = 1'b1;
    req_write = v.wr;
    req_addr  = v.addr;
    req_wdata = v.wdata;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // runs one access and measures its phases at the pins
  task automatic run_access(input vec_t v, input string tag);
    int n_addr = 0, n_data = 0, n_turn = 0, n_rsp = 0, guard = 0;
    bit addr_ok = 1, strobe_ok = 1, drive_ok = 1, rsp_pos_ok = 1, rdata_ok = 1, busy_ok = 1;
    int unsigned exp_rd = int'(v.addr[15:0] ^ 16'h5A5A);
    issue(v);
    while (!req_ready && guard < 2000) begin
      if (!mem_cs_n && mem_oe_n && mem_we_n) begin
        n_addr++;
        if (mem_addr != v.addr) addr_ok = 0;
        if (mem_dout_en) drive_ok = 0;
      end else if (!mem_cs_n) begin
        n_data++;
        if (mem_addr != v.addr) addr_ok = 0;
        if (v.wr && !(mem_oe_n && !mem_we_n && mem_dout_en && mem_dout == v.wdata)) drive_ok = 0;
        if (!v.wr && !(!mem_oe_n && mem_we_n && !mem_dout_en)) strobe_ok = 0;
      end else begin
        n_turn++;
        if (!mem_oe_n || !mem_we_n || mem_dout_en) strobe_ok = 0;
      end
      if (rsp_valid) begin
        n_rsp++;
        if (!(mem_cs_n && n_turn == 1)) rsp_pos_ok = 0;
        if (!v.wr && rsp_rdata != exp_rd[15:0]) rdata_ok = 0;
      end
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      guard++;
    end
    check(n_addr == int'(v.exp_addr_cyc), {tag, " R2 R3 setup+hold cycles"}, n_addr, int'(v.exp_addr_cyc));
    check(n_data == int'(v.exp_data_cyc), {tag, " R4 data cycles"}, n_data, int'(v.exp_data_cyc));
    check(n_turn == int'(v.exp_turn_cyc), {tag, " R5 turnaround cycles"}, n_turn, int'(v.exp_turn_cyc));
    check(strobe_ok, {tag, " R4 strobe levels"}, strobe_ok, 1);
    check(drive_ok, {tag, " R7 write drive"}, drive_ok, 1);
    check(addr_ok, {tag, " R12 address stable"}, addr_ok, 1);
    check(n_rsp == 1 && rsp_pos_ok, {tag, " R8 response pulse"}, n_rsp, 1);
    if (!v.wr) check(rdata_ok, {tag, " R8 read data"}, int'(rsp_rdata), int'(exp_rd));
  endtask

  // wait held active from before the access, released inside the data phase
  task automatic wait_access(input bit pol, input string tag);
    vec_t v = '{4'd1, 4'd1, 8'd1, 4'd0, 1'b0, 20'h0F0F0, 16'h0000, 10'd4, 10'd4, 10'd1};
    int n_addr = 0, n_tail = 0, guard = 0;
    bit held = 1;
    @(negedge clk);
    cfg_ctrl = 16'h0001 | 16'h8000 | (pol ? 16'h0200 : 16'h0000);
    mem_wait = pol;
    repeat (3) @(negedge clk);
    issue(v);
    while (mem_oe_n && guard < 100) begin
      if (!mem_cs_n) n_addr++;
      @(negedge clk);
      guard++;
    end
    check(n_addr == 4, {tag, " R11 address phases not stretched"}, n_addr, 4);
    for (int i = 0; i < 8; i++) begin
      if (mem_oe_n) held = 0;
      @(negedge clk);
    end
    check(held, {tag, " R10 data phase frozen while wait active"}, held, 1);
    mem_wait = !pol;
    while (!mem_oe_n && n_tail < 50) begin
      @(posedge clk);
      @(negedge clk);
      n_tail++;
    end
    check(n_tail == 5, {tag, " R10 cycles from release to data end"}, n_tail, 5);
    check(rsp_valid && rsp_rdata == (16'hF0F0 ^ 16'h5A5A), {tag, " R8 read data after wait"},
          int'(rsp_rdata), int'(16'hF0F0 ^ 16'h5A5A));
    guard = 0;
    while (!req_ready && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    cfg_ctrl = 16'h0001;
    mem_wait = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    vec_t v;
    int   n;
    bit   ok;
    repeat (3) @(negedge clk);
    // R1 reset state (bank enabled in the control word)
    check(req_ready && mem_cs_n && mem_oe_n && mem_we_n && !mem_dout_en && !rsp_valid,
          "R1 state during reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en, rsp_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) run_access(VECS[i], $sformatf("vec%0d", i));

    // R9: wait disabled, pin at a level that would be active-high
    @(negedge clk);
    cfg_ctrl = 16'h0201;
    mem_wait = 1'b1;
    run_access(VECS[0], "R9 wait disabled");
    // R9: wait enabled active-high, pin low (inactive)
    cfg_ctrl = 16'h8201;
    mem_wait = 1'b0;
    run_access(VECS[0], "R9 wait inactive level");
    // R9: mode fields do not alter timing
    cfg_ctrl = 16'h403F;
    run_access(VECS[1], "R9 mode bits ignored");
    cfg_ctrl = 16'h0001;

    wait_access(1'b1, "active-high");
    wait_access(1'b0, "active-low");

    // R1: bank disabled blocks requests
    @(negedge clk);
    cfg_ctrl = 16'h0000;
    req_valid = 1'b1;
    ok = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (req_ready || !mem_cs_n) ok = 0;
    end
    check(ok, "R1 bank disabled holds off request", ok, 1);
    // R1: enabling the bank lets the held request in, then ready stays low while busy
    v = VECS[0];
    req_write = 1'b0;
    req_addr = v.addr;
    cfg_addr_setup = v.aset; cfg_addr_hold = v.ahld;
    cfg_data_setup = v.dset; cfg_turnaround = v.turn;
    cfg_ctrl = 16'h0001;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!mem_cs_n && !req_ready, "R1 held request accepted once enabled", mem_cs_n, 0);
    n = 0;
    while (!req_ready && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == 8, "R1 R5 ready returns after full access", n, 8);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule